// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Status Byte

This block is a single-channel asynchronous serial transmitter and receiver. Characters carry eight data bits sent least significant bit first. Each character can have an optional parity bit, even or odd, and one or two stop bits. The bit time is a fixed number of system clocks, equal to the oversampling factor times a clock divider parameter. A host reaches the block over a minimal register bus with two addresses. Address 0 writes the transmit holding register and reads the receive data register. Address 1 reads an eight-bit status byte that has no read side effects.

The receiver oversamples the line at sixteen times the bit rate and samples each bit near its middle. It drops a start bit that has gone high again by the half-bit point. Each finished character goes into the receive data register, and the receiver raises flags for data available, parity error, overrun, framing error and break. All five flags clear together when the host reads the receive data register.

The transmitter reports whether its holding register is free and whether the whole character, including its last stop bit, has left the shift register. A clear-to-send input level appears in the status byte. A loopback option feeds the transmit stream into the receiver and holds the external transmit pin high. While loopback is on, the status bit that normally shows clear-to-send shows the data-available flag instead.

Top module: `uart_stat_top`

## Requirements
- R1: After reset the status byte has data-available, parity error, overrun, framing error and break at 0, holding-empty and transmitter-empty at 1, and the clear-to-send bit equal to the `cts_in` level.
- R2: Status bit positions are: bit 7 data available, bit 6 parity error, bit 5 overrun, bit 4 framing error, bit 3 break, bit 2 holding register empty, bit 1 transmitter empty, bit 0 clear-to-send.
- R3: A completed character is stored in the receive data register (address 0) and sets data-available. A bus read at address 0 (`bus_rd` with `bus_addr`=0) clears data-available.
- R4: With `cfg_par_en`=1, parity is even when `cfg_par_odd`=0 and odd when it is 1. A parity bit that disagrees sets the parity error flag. A read at address 0 clears the parity, overrun, framing and break flags.
- R5: When a character completes while data-available is still 1, the overrun flag sets, the register keeps the older byte and the new character is discarded.
- R6: A stop bit that is sampled low sets the framing error flag. This applies to either stop bit when `cfg_two_stop`=1.
- R7: The break flag sets when the data bits, the parity bit (if enabled) and every stop bit are all sampled as 0.
- R8: A write at address 0 clears holding-empty. Holding-empty sets again when the byte moves to the shift register. Transmitter-empty is 1 only when no byte is held and the final stop bit has been sent completely.
- R9: The transmitted frame is one low start bit, then 8 data bits LSB first, then the parity bit if enabled, then one or two high stop bits. Each bit lasts OVS*CLK_DIV clocks.
- R10: With `cfg_loop`=1, `ser_tx` stays 1, the receiver takes the internal transmit stream and ignores `ser_rx`, and status bit 0 shows data-available in place of `cts_in`.
- R11: A low pulse on the receive line that has ended before the half-bit sample produces no character, and the receiver then accepts the next valid frame.
- R12: `cfg_two_stop`=1 gives two stop bits on transmit and checks two stop bits on receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 status |
| bus_wr | input | 1 | Write strobe (address 0 loads the transmit holding register) |
| bus_rd | input | 1 | Read strobe (address 0 clears the receive flags) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | max(8,DATA_W) | Read data, combinational from bus_addr |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_loop | input | 1 | Internal loopback enable |
| cts_in | input | 1 | Clear-to-send input level |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
Random frames mix random bytes, parity modes and stop-bit counts with parity bits and stop bits that are sometimes corrupted. The flag combinations therefore show whether parity, framing and break are each decoded separately. Directed frames cover the cases that random stimulus rarely reaches. An all-zero frame with a low stop bit separates break from an ordinary framing error. Two unread frames in a row separate discard-on-overrun from overwrite. A short low glitch separates start-bit rejection from a false character. Back-to-back transmit writes show the difference between holding-empty and transmitter-empty, and a loopback run with the external receive line held low shows that the line really is disconnected.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
   // status byte bit positions (host software decodes these)
   localparam int ST_AVAIL   = 7;
   localparam int ST_PARERR  = 6;
   localparam int ST_OVRUN   = 5;
   localparam int ST_FRMERR  = 4;
   localparam int ST_BREAK   = 3;
   localparam int ST_THEMPTY = 2;
   localparam int ST_SHEMPTY = 1;
   localparam int ST_CTS     = 0;

   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP, PH_WAITHI
   } phase_e;

   typedef struct packed {
      logic perr;
      logic ferr;
      logic brk;
   } rx_err_t;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_DIV <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(CLK_DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = (cnt_q == CW'(CLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng
   import uart_stat_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              thr_empty,
   output logic              sh_empty,
   output logic              tx_line
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W);

   phase_e            ph_q;
   logic [CW-1:0]     cnt_q;
   logic [BW-1:0]     idx_q;
   logic [DATA_W-1:0] hold_q, sh_q;
   logic              full_q, par_q, pen_q, two_q, stop2_q, line_q;
   logic              bit_end;

   assign bit_end = tick && (cnt_q == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         hold_q  <= '0;
         sh_q    <= '0;
         full_q  <= 1'b0;
         par_q   <= 1'b0;
         pen_q   <= 1'b0;
         two_q   <= 1'b0;
         stop2_q <= 1'b0;
         line_q  <= 1'b1;
      end else begin
         if (tick && ph_q != PH_IDLE) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
         end
         case (ph_q)
            PH_IDLE: begin
               if (full_q) begin
                  sh_q    <= hold_q;
                  par_q   <= (^hold_q) ^ par_odd;
                  pen_q   <= par_en;
                  two_q   <= two_stop;
                  stop2_q <= 1'b0;
                  full_q  <= 1'b0;
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  line_q  <= 1'b0;
                  ph_q    <= PH_START;
               end
            end
            PH_START: begin
               if (bit_end) begin
                  line_q <= sh_q[0];
                  ph_q   <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (bit_end) begin
                  if (idx_q == BW'(DATA_W - 1)) begin
                     if (pen_q) begin
                        line_q <= par_q;
                        ph_q   <= PH_PAR;
                     end else begin
                        line_q <= 1'b1;
                        ph_q   <= PH_STOP;
                     end
                  end else begin
                     sh_q   <= sh_q >> 1;
                     line_q <= sh_q[1];
                     idx_q  <= idx_q + 1'b1;
                  end
               end
            end
            PH_PAR: begin
               if (bit_end) begin
                  line_q <= 1'b1;
                  ph_q   <= PH_STOP;
               end
            end
            PH_STOP: begin
               if (bit_end) begin
                  if (two_q && !stop2_q) begin
                     stop2_q <= 1'b1;
                  end else begin
                     ph_q <= PH_IDLE;
                  end
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
         // a host write overrides the load-time clear of the full flag
         if (wr) begin
            hold_q <= wdata;
            full_q <= 1'b1;
         end
      end
   end

   assign thr_empty = !full_q;
   assign sh_empty  = (ph_q == PH_IDLE) && !full_q;
   assign tx_line   = line_q;
endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng
   import uart_stat_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_in,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output rx_err_t           rx_err
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(DATA_W);

   phase_e            ph_q;
   logic [CW-1:0]     cnt_q;
   logic [BW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              par_q, stop2_q, any_lo_q, all_lo_q;
   logic              mid_start, bit_end, last_stop, any_lo, all_lo;

   assign mid_start = tick && (cnt_q == CW'(OVS / 2 - 1));
   assign bit_end   = tick && (cnt_q == CW'(OVS - 1));
   assign last_stop = !two_stop || stop2_q;
   assign any_lo    = any_lo_q || !rx_in;
   assign all_lo    = all_lo_q && !rx_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         cnt_q    <= '0;
         idx_q    <= '0;
         sh_q     <= '0;
         par_q    <= 1'b0;
         stop2_q  <= 1'b0;
         any_lo_q <= 1'b0;
         all_lo_q <= 1'b1;
         done     <= 1'b0;
         rx_byte  <= '0;
         rx_err   <= '0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (tick && !rx_in) begin
                  cnt_q <= '0;
                  ph_q  <= PH_START;
               end
            end
            PH_START: begin
               if (mid_start) begin
                  cnt_q <= '0;
                  idx_q <= '0;
                  ph_q  <= rx_in ? PH_IDLE : PH_DATA;
               end else if (tick) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DATA: begin
               if (tick) cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
               if (bit_end) begin
                  sh_q <= {rx_in, sh_q[DATA_W-1:1]};
                  if (idx_q == BW'(DATA_W - 1)) begin
                     stop2_q  <= 1'b0;
                     any_lo_q <= 1'b0;
                     all_lo_q <= 1'b1;
                     ph_q     <= par_en ? PH_PAR : PH_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            PH_PAR: begin
               if (tick) cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
               if (bit_end) begin
                  par_q <= rx_in;
                  ph_q  <= PH_STOP;
               end
            end
            PH_STOP: begin
               if (tick) cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
               if (bit_end) begin
                  any_lo_q <= any_lo;
                  all_lo_q <= all_lo;
                  if (last_stop) begin
                     done        <= 1'b1;
                     rx_byte     <= sh_q;
                     rx_err.perr <= par_en && (par_q != ((^sh_q) ^ par_odd));
                     rx_err.ferr <= any_lo;
                     rx_err.brk  <= (sh_q == '0) && (!par_en || !par_q) && all_lo;
                     ph_q        <= rx_in ? PH_IDLE : PH_WAITHI;
                  end else begin
                     stop2_q <= 1'b1;
                  end
               end
            end
            PH_WAITHI: begin
               if (rx_in) ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_stat_top.sv
module uart_stat_top
   import uart_stat_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int BUS_W      = (DATA_W > 8) ? DATA_W : 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              cfg_loop,
   input  logic              cts_in,
   input  logic              ser_rx,
   output logic              ser_tx
);
   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("uart_stat_top: OVS must be at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_stat_top: DATA_W must be 5..9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_stat_top: SYNC_STAGES must be at least 2");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("uart_stat_top: CLK_DIV must be positive");
      end
   endgenerate

   logic              tick, tx_line, rx_src, rx_in;
   logic              thr_empty, sh_empty, rx_done;
   logic              rd_data, wr_data;
   logic [DATA_W-1:0] rx_byte, rx_reg;
   rx_err_t           rx_err;
   logic              rda_q, pe_q, oe_q, fe_q, brk_q;
   logic [7:0]        status;
   logic [SYNC_STAGES-1:0] sync_q;

   assign rd_data = bus_rd && !bus_addr;
   assign wr_data = bus_wr && !bus_addr;

   uart_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   uart_tx_eng #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
      .wr(wr_data), .wdata(bus_wdata),
      .thr_empty(thr_empty), .sh_empty(sh_empty), .tx_line(tx_line)
   );

   // receive input: loopback mux then synchronizer chain
   assign rx_src = cfg_loop ? tx_line : ser_rx;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q[s] <= 1'b1;
            end else begin
               sync_q[s] <= (s == 0) ? rx_src : sync_q[(s == 0) ? 0 : s - 1];
            end
         end
      end
   endgenerate
   assign rx_in = sync_q[SYNC_STAGES-1];

   uart_rx_eng #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
      .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
      .done(rx_done), .rx_byte(rx_byte), .rx_err(rx_err)
   );

   // receive flags: a data read clears, a completing character sets
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rda_q  <= 1'b0;
         pe_q   <= 1'b0;
         oe_q   <= 1'b0;
         fe_q   <= 1'b0;
         brk_q  <= 1'b0;
         rx_reg <= '0;
      end else begin
         if (rd_data) begin
            rda_q <= 1'b0;
            pe_q  <= 1'b0;
            oe_q  <= 1'b0;
            fe_q  <= 1'b0;
            brk_q <= 1'b0;
         end
         if (rx_done) begin
            if (rda_q && !rd_data) begin
               oe_q <= 1'b1;
            end else begin
               rx_reg <= rx_byte;
               rda_q  <= 1'b1;
               pe_q   <= rx_err.perr;
               fe_q   <= rx_err.ferr;
               brk_q  <= rx_err.brk;
            end
         end
      end
   end

   always_comb begin
      status             = '0;
      status[ST_AVAIL]   = rda_q;
      status[ST_PARERR]  = pe_q;
      status[ST_OVRUN]   = oe_q;
      status[ST_FRMERR]  = fe_q;
      status[ST_BREAK]   = brk_q;
      status[ST_THEMPTY] = thr_empty;
      status[ST_SHEMPTY] = sh_empty;
      status[ST_CTS]     = cfg_loop ? rda_q : cts_in;
   end

   assign bus_rdata = bus_addr ? BUS_W'(status) : BUS_W'(rx_reg);
   assign ser_tx    = cfg_loop ? 1'b1 : tx_line;
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_data,
   input logic              wr_data,
   input logic              rx_done,
   input logic [7:0]        status,
   input logic [DATA_W-1:0] rx_reg,
   input logic              tx_line
);
   p_rda_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> status[7]);

   p_rda_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !status[7]);

   p_flags_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> (status[6:3] == 4'b0000));

   p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && status[7] && !rd_data) |=> (status[5] && $stable(rx_reg)));

   p_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !status[2]);

   p_txe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> (status[2] && tx_line));
endmodule

bind uart_stat_top uart_stat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .wr_data(wr_data),
   .rx_done(rx_done), .status(status), .rx_reg(rx_reg), .tx_line(tx_line)
);

// File: tb/tb_uart_stat_top.sv
module tb_uart_stat_top;
   localparam int DIV = 4;
   localparam int OVS = 16;
   localparam int BT  = DIV * OVS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_loop = 0;
   logic       cts_in = 1'b1, ser_rx = 1'b1, ser_tx;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   uart_stat_top #(.DATA_W(8), .OVS(OVS), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_loop(cfg_loop),
      .cts_in(cts_in), .ser_rx(ser_rx), .ser_tx(ser_tx)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic get_stat(output logic [7:0] s);
      @(negedge clk);
      bus_addr = 1'b1;
      #1 s = bus_rdata;
   endtask

   task automatic get_data(output logic [7:0] d);
      @(negedge clk);
      bus_addr = 1'b0;
      bus_rd   = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd   = 1'b0;
      bus_addr = 1'b1;
   endtask

   task automatic put_data(input logic [7:0] d);
      @(negedge clk);
      bus_addr  = 1'b0;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = 1'b1;
   endtask

   task automatic hold_bit(input logic v);
      ser_rx = v;
      repeat (BT) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic pen, input logic pbit,
                             input logic two, input logic st1, input logic st2);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (pen) hold_bit(pbit);
      hold_bit(st1);
      if (two) hold_bit(st2);
      ser_rx = 1'b1;
      repeat (BT) @(negedge clk);
   endtask

   // expected {parity error, framing error, break}
   function automatic logic [2:0] exp_flags(input logic [7:0] d, input logic pen,
         input logic odd, input logic pbit, input logic two, input logic st1, input logic st2);
      logic pe, fe, br;
      pe = pen && (pbit != ((^d) ^ odd));
      fe = !st1 || (two && !st2);
      br = (d == 8'h00) && (!pen || !pbit) && !st1 && (!two || !st2);
      return {pe, fe, br};
   endfunction

   function automatic logic [11:0] tx_frame(input logic [7:0] d, input logic odd);
      return {2'b11, (^d) ^ odd, d, 1'b0};
   endfunction

   task automatic capture(output logic [11:0] bits);
      @(negedge ser_tx);
      repeat (BT / 2) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         bits[i] = ser_tx;
         if (i < 11) repeat (BT) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  s, d;
      logic [11:0] f1, f2;
      logic        tx_stayed_high;
      void'($urandom(32'h1A2B3C4D));

      repeat (3) @(negedge clk);
      // R1 / R2: reset image, CTS bit follows pin
      get_stat(s);
      chk("R1 reset status", s, 8'b0000_0111);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      get_stat(s);
      chk("R1 status after release", s, 8'b0000_0111);

      // R2 / R10: CTS reflects the pin when not looped back
      cts_in = 1'b0;
      get_stat(s);
      chk("R2 cts bit low", s[0], 1'b0);
      cts_in = 1'b1;
      get_stat(s);
      chk("R2 cts bit high", s[0], 1'b1);

      // R3 / R4 / R6 / R7 / R12: random frames with corruption
      for (int it = 0; it < 24; it++) begin
         logic [7:0] dv;
         logic pen, odd, two, pbit, st1, st2;
         logic [2:0] ef;
         dv  = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
         pen = 1'($urandom);
         odd = 1'($urandom);
         two = 1'($urandom);
         pbit = ((^dv) ^ odd) ^ ($urandom % 4 == 0);
         st1 = ($urandom % 4 != 0);
         st2 = ($urandom % 4 != 0);
         if (dv == 8'h00 && $urandom % 2 == 0) begin
            pbit = 1'b0; st1 = 1'b0; st2 = 1'b0;
         end
         cfg_par_en = pen; cfg_par_odd = odd; cfg_two_stop = two;
         ef = exp_flags(dv, pen, odd, pbit, two, st1, st2);
         send_frame(dv, pen, pbit, two, st1, st2);
         get_stat(s);
         chk("R3 R4 R6 R7 R12 flags after frame", {24'h0, s[7:3]},
             {27'h0, 1'b1, ef[2], 1'b0, ef[1], ef[0]});
         get_data(d);
         chk("R3 received byte", d, dv);
         get_stat(s);
         chk("R4 flags cleared by data read", s[7:3], 5'b00000);
      end

      // R7: directed break, all zero including stop, with even parity
      cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
      send_frame(8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      get_stat(s);
      chk("R7 break frame flags", s[7:3], 5'b10011);
      get_data(d);
      // R6: only second stop low -> framing error but no break
      send_frame(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      get_stat(s);
      chk("R6 R12 second stop low", s[7:3], 5'b10010);
      get_data(d);

      // R5: overrun keeps older byte
      cfg_par_en = 0; cfg_two_stop = 0;
      send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      get_stat(s);
      chk("R5 overrun flags", s[7:3], 5'b10100);
      get_data(d);
      chk("R5 older byte kept", d, 8'h11);
      get_stat(s);
      chk("R5 overrun cleared by read", s[7:3], 5'b00000);

      // R11: glitch shorter than half a bit is rejected
      ser_rx = 1'b0;
      repeat (BT / 4) @(negedge clk);
      ser_rx = 1'b1;
      repeat (2 * BT) @(negedge clk);
      get_stat(s);
      chk("R11 glitch gives no character", s[7], 1'b0);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      get_data(d);
      chk("R11 next frame accepted", d, 8'hC3);

      // R8 / R9 / R12: transmit two back-to-back frames, even parity, two stops
      cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
      fork
         begin
            capture(f1);
            capture(f2);
         end
         begin
            put_data(8'hA5);
            #1 chk("R8 holding register full after write", bus_rdata[2:1], 2'b00);
            @(negedge clk);
            #1 chk("R8 holding empty after move, shifter busy", bus_rdata[2:1], 2'b10);
            put_data(8'h3C);
            #1 chk("R8 second byte waits in holding register", bus_rdata[2:1], 2'b00);
         end
      join
      chk("R9 R12 first transmitted frame", f1, tx_frame(8'hA5, 1'b0));
      chk("R9 R12 second transmitted frame", f2, tx_frame(8'h3C, 1'b0));
      get_stat(s);
      chk("R8 still sending last stop", s[2:1], 2'b10);
      repeat (BT) @(negedge clk);
      get_stat(s);
      chk("R8 transmitter empty after last stop", s[2:1], 2'b11);

      // R9: odd parity single frame
      cfg_par_odd = 1;
      fork
         capture(f1);
         put_data(8'h0F);
      join
      chk("R9 odd parity frame", f1, tx_frame(8'h0F, 1'b1));
      repeat (2 * BT) @(negedge clk);

      // R10: loopback with external line held low
      cfg_par_en = 0; cfg_two_stop = 0;
      cfg_loop = 1;
      repeat (4) @(negedge clk);
      ser_rx = 1'b0;
      cts_in = 1'b0;
      tx_stayed_high = 1'b1;
      fork
         begin
            put_data(8'h5A);
         end
         begin
            repeat (14 * BT) begin
               @(negedge clk);
               if (ser_tx !== 1'b1) tx_stayed_high = 1'b0;
            end
         end
      join
      chk("R10 ser_tx idle in loopback", tx_stayed_high, 1'b1);
      get_stat(s);
      chk("R10 char received through loopback", s[7:3], 5'b10000);
      chk("R10 status bit0 shows data available", s[0], 1'b1);
      get_data(d);
      chk("R10 loopback byte", d, 8'h5A);
      get_stat(s);
      chk("R10 status bit0 follows cleared flag", s[0], 1'b0);
      ser_rx = 1'b1;
      repeat (4) @(negedge clk);
      cfg_loop = 1'b0;
      repeat (4) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule